// File: doc/BRIEF.md
# Video Raster Format Detector

This block watches a parallel digital video stream, one word per pixel clock, and works out the shape of its raster. The line and field timing can come from two places. One is the timing reference codes embedded in the word stream. The other is a set of external H, V and F timing inputs. A select input chooses which one is used. From that timing the block measures four things: how many samples a line has, how many of those are active, how many lines a field has, and how many of those lines are active.

The four counts, a lock flag and an interlace flag are registered outputs. The counts change only at one fixed point in each frame, so a reader never sees a half-updated set. A watchdog covers the case where the video words stop but the pixel clock keeps running. When no timing event arrives for too long, the watchdog drops lock and clears the counts.

The detector works only while both the standard-video input and the processing-enable input are high. Whenever either one is low, the whole block is held cleared.

Top module: `raster_fmt_detect`

## Requirements
- R1: With `src_sel`=0, timing events come from the embedded code sequence 3FF, 000, 000, XYZ. In the XYZ word, bit 8 is F, bit 7 is V and bit 6 is H, and H=1 marks end of active video (EAV) while H=0 marks start of active video (SAV). With `src_sel`=1, a rising edge of `ext_h` is an EAV, a falling edge of `ext_h` is an SAV, and `ext_v` and `ext_f` are sampled at that edge.
- R2: `samples_total` reports the number of pixel clocks between two consecutive EAV events.
- R3: `samples_active` reports the number of active words per line. With embedded codes this is the words between the SAV code and the next EAV code. With external timing it is the clocks for which `ext_h` is low.
- R4: A field starts at an EAV whose V is 1 when the previous EAV had V=0. `lines_total` counts the EAVs in a field. `lines_active` counts the EAVs in a field that carry V=0.
- R5: A frame starts at a field start with F=0. Line 1 begins at that EAV. The four counts, the lock flag and the interlace flag change only at the EAV that ends line 12 of a frame, apart from clearing.
- R6: At each update, `std_locked` goes high if the new total-sample and total-line values are both non-zero and equal to the values published before. Otherwise it goes low. Lock therefore needs two matching frames in a row.
- R7: `interlaced` goes high after a frame in which F changed between EAVs. It goes low only after two frames in a row with constant F.
- R8: If no timing event arrives for `WDOG_LIMIT` pixel clocks, `std_locked` and all four counts go to zero.
- R9: Unless `std_mode` and `proc_en` are both high, all outputs are held at zero.
- R10: Sample counts saturate at 2^`SAMP_W`-1 and line counts saturate at 2^`LINE_W`-1. They do not wrap.
- R11: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_mode | input | 1 | Standard-video mode; must be high for processing |
| proc_en | input | 1 | Processing enable; must be high for processing |
| src_sel | input | 1 | Timing source: 0 embedded codes, 1 external H/V/F |
| vid_data | input | DATA_W | Video word stream |
| ext_h | input | 1 | External horizontal timing (high in blanking) |
| ext_v | input | 1 | External vertical blanking |
| ext_f | input | 1 | External field identifier |
| samples_total | output | SAMP_W | Total samples per line |
| samples_active | output | SAMP_W | Active samples per line |
| lines_total | output | LINE_W | Total lines per field |
| lines_active | output | LINE_W | Active lines per field |
| std_locked | output | 1 | Raster lock flag |
| interlaced | output | 1 | 1 interlaced, 0 progressive |

## Verification
The bench builds the block with `SAMP_W`=6, `LINE_W`=5 and `WDOG_LIMIT`=200. With these values an 80-sample line and a 40-line field overrun the counters, so saturation can be checked without rasters of full size. The short limit lets a dropped-data gap trip the watchdog in a few hundred clocks. Small rasters of 40 and 48 samples keep each frame under 1,700 clocks. This leaves room for lock, interlace-to-progressive changes, both timing sources and the line-12 update point in one run.

// File: rtl/rfd_pkg.sv
package rfd_pkg;
  // One decoded timing event, common to both timing sources
  typedef struct packed {
    logic vld;
    logic f;
    logic v;
    logic h;
  } rfd_evt_t;

  // Active-sample correction: code words counted after the SAV marker
  localparam logic [2:0] TRS_ACT_OFFSET = 3'd4;
  localparam logic [2:0] EXT_ACT_OFFSET = 3'd0;
endpackage

// File: rtl/rfd_rst_sync.sv
module rfd_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) stage_q <= 2'b00;
    else           stage_q <= stage_d;
  end

  assign rst_n_out = stage_q[1];
endmodule

// File: rtl/rfd_trs_decode.sv
module rfd_trs_decode import rfd_pkg::*; #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [DATA_W-1:0] din,
  output rfd_evt_t          evt
);
  localparam int BIT_F = DATA_W - 2;
  localparam int BIT_V = DATA_W - 3;
  localparam int BIT_H = DATA_W - 4;
  localparam logic [DATA_W-1:0] WORD_ONES  = '1;
  localparam logic [DATA_W-1:0] WORD_ZEROS = '0;

  logic [DATA_W-1:0] w0_q, w1_q, w2_q;
  logic [DATA_W-1:0] w0_d, w1_d, w2_d;
  logic              hdr_seen;

  // Newest word is w0, oldest w2
  always_comb begin
    if (clr) begin
      w0_d = '0;
      w1_d = '0;
      w2_d = '0;
    end else begin
      w0_d = din;
      w1_d = w0_q;
      w2_d = w1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w0_q <= '0;
      w1_q <= '0;
      w2_q <= '0;
    end else begin
      w0_q <= w0_d;
      w1_q <= w1_d;
      w2_q <= w2_d;
    end
  end

  assign hdr_seen = (w2_q == WORD_ONES) && (w1_q == WORD_ZEROS) && (w0_q == WORD_ZEROS);

  always_comb begin
    evt.vld = hdr_seen && !clr;
    evt.f   = din[BIT_F];
    evt.v   = din[BIT_V];
    evt.h   = din[BIT_H];
  end
endmodule

// File: rtl/rfd_ext_decode.sv
module rfd_ext_decode import rfd_pkg::*; (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  logic     h_in,
  input  logic     v_in,
  input  logic     f_in,
  output rfd_evt_t evt
);
  logic h_q, h_d;

  always_comb h_d = clr ? 1'b0 : h_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) h_q <= 1'b0;
    else        h_q <= h_d;
  end

  // Any edge of H is an event; its level tells EAV (1) from SAV (0)
  always_comb begin
    evt.vld = (h_in != h_q) && !clr;
    evt.h   = h_in;
    evt.v   = v_in;
    evt.f   = f_in;
  end
endmodule

// File: rtl/rfd_watchdog.sv
module rfd_watchdog #(
  parameter int CNT_W = 16,
  parameter int LIMIT = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic evt_vld,
  output logic expired
);
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

  logic [CNT_W-1:0] idle_q, idle_d;

  always_comb begin
    if (clr || evt_vld)        idle_d = '0;
    else if (idle_q != LIMIT_V) idle_d = idle_q + 1'b1;
    else                        idle_d = idle_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_q <= '0;
    else        idle_q <= idle_d;
  end

  assign expired = (idle_q == LIMIT_V);
endmodule

// File: rtl/rfd_measure.sv
module rfd_measure import rfd_pkg::*; #(
  parameter int SAMP_W   = 13,
  parameter int LINE_W   = 11,
  parameter int PUB_LINE = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  rfd_evt_t          evt,
  input  logic [2:0]        act_off,
  output logic [SAMP_W-1:0] st_o,
  output logic [SAMP_W-1:0] sa_o,
  output logic [LINE_W-1:0] lt_o,
  output logic [LINE_W-1:0] la_o,
  output logic              lock_o,
  output logic              il_o,
  output logic              publish_o
);
  localparam logic [SAMP_W-1:0] S_MAX = '1;
  localparam logic [LINE_W-1:0] L_MAX = '1;
  localparam logic [SAMP_W-1:0] S_ONE = SAMP_W'(1);
  localparam logic [LINE_W-1:0] L_ONE = LINE_W'(1);
  localparam logic [LINE_W-1:0] L_PUB = LINE_W'(PUB_LINE);

  // Line-level counters and latches
  logic [SAMP_W-1:0] samp_q, samp_d, act_q, act_d;
  logic [SAMP_W-1:0] ln_tot_q, ln_tot_d, ln_act_q, ln_act_d;
  // Field / frame counters and latches
  logic [LINE_W-1:0] fl_q, fl_d, al_q, al_d;
  logic [LINE_W-1:0] fld_tot_q, fld_tot_d, fld_act_q, fld_act_d;
  logic [LINE_W-1:0] lc_q, lc_d;
  logic              v_q, v_d, f_q, f_d;
  logic              tog_q, tog_d, ilp_q, ilp_d;
  logic [1:0]        cf_q, cf_d;
  // Published state
  logic [SAMP_W-1:0] st_q, st_d, sa_q, sa_d;
  logic [LINE_W-1:0] lt_q, lt_d, la_q, la_d;
  logic              lock_q, lock_d, il_q, il_d;

  logic              eav, sav, vrise, fstart, tog_now, frame_tog, publish;
  logic [SAMP_W-1:0] off_w, act_trim;

  always_comb begin
    eav       = evt.vld && evt.h;
    sav       = evt.vld && !evt.h;
    vrise     = eav && evt.v && !v_q;
    fstart    = vrise && !evt.f;
    tog_now   = eav && (evt.f != f_q);
    frame_tog = tog_q || tog_now;
    publish   = eav && (lc_q == L_PUB) && !fstart;
    off_w     = {{(SAMP_W-3){1'b0}}, act_off};
    act_trim  = (act_q > off_w) ? (act_q - off_w) : '0;
  end

  // Sample-level next state
  always_comb begin
    samp_d   = eav ? S_ONE : ((samp_q == S_MAX) ? samp_q : samp_q + 1'b1);
    act_d    = sav ? S_ONE : ((act_q == S_MAX) ? act_q : act_q + 1'b1);
    ln_tot_d = eav ? samp_q : ln_tot_q;
    ln_act_d = eav ? act_trim : ln_act_q;
  end

  // Line-level next state
  always_comb begin
    v_d = eav ? evt.v : v_q;
    f_d = eav ? evt.f : f_q;

    if (vrise)    fl_d = L_ONE;
    else if (eav) fl_d = (fl_q == L_MAX) ? fl_q : fl_q + 1'b1;
    else          fl_d = fl_q;

    if (vrise)              al_d = '0;
    else if (eav && !evt.v) al_d = (al_q == L_MAX) ? al_q : al_q + 1'b1;
    else                    al_d = al_q;

    fld_tot_d = vrise ? fl_q : fld_tot_q;
    fld_act_d = vrise ? al_q : fld_act_q;

    if (fstart)   lc_d = L_ONE;
    else if (eav) lc_d = (lc_q == L_MAX) ? lc_q : lc_q + 1'b1;
    else          lc_d = lc_q;
  end

  // Frame-level interlace tracking
  always_comb begin
    tog_d = tog_q;
    ilp_d = ilp_q;
    cf_d  = cf_q;
    if (fstart) begin
      tog_d = 1'b0;
      if (frame_tog) begin
        ilp_d = 1'b1;
        cf_d  = 2'd0;
      end else begin
        if (cf_q != 2'd0) ilp_d = 1'b0;
        cf_d = (cf_q == 2'd3) ? cf_q : cf_q + 2'd1;
      end
    end else if (tog_now) begin
      tog_d = 1'b1;
    end
  end

  // Publish next state; compares against the previously published set
  always_comb begin
    st_d   = st_q;
    sa_d   = sa_q;
    lt_d   = lt_q;
    la_d   = la_q;
    lock_d = lock_q;
    il_d   = il_q;
    if (publish) begin
      st_d   = ln_tot_q;
      sa_d   = ln_act_q;
      lt_d   = fld_tot_q;
      la_d   = fld_act_q;
      il_d   = ilp_q;
      lock_d = (ln_tot_q == st_q) && (fld_tot_q == lt_q) &&
               (ln_tot_q != '0) && (fld_tot_q != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0; act_q <= '0; ln_tot_q <= '0; ln_act_q <= '0;
      fl_q <= '0; al_q <= '0; fld_tot_q <= '0; fld_act_q <= '0; lc_q <= '0;
      v_q <= 1'b0; f_q <= 1'b0; tog_q <= 1'b0; ilp_q <= 1'b0; cf_q <= 2'd0;
      st_q <= '0; sa_q <= '0; lt_q <= '0; la_q <= '0;
      lock_q <= 1'b0; il_q <= 1'b0;
    end else if (clr) begin
      samp_q <= '0; act_q <= '0; ln_tot_q <= '0; ln_act_q <= '0;
      fl_q <= '0; al_q <= '0; fld_tot_q <= '0; fld_act_q <= '0; lc_q <= '0;
      v_q <= 1'b0; f_q <= 1'b0; tog_q <= 1'b0; ilp_q <= 1'b0; cf_q <= 2'd0;
      st_q <= '0; sa_q <= '0; lt_q <= '0; la_q <= '0;
      lock_q <= 1'b0; il_q <= 1'b0;
    end else begin
      samp_q <= samp_d; act_q <= act_d; ln_tot_q <= ln_tot_d; ln_act_q <= ln_act_d;
      fl_q <= fl_d; al_q <= al_d; fld_tot_q <= fld_tot_d; fld_act_q <= fld_act_d;
      lc_q <= lc_d;
      v_q <= v_d; f_q <= f_d; tog_q <= tog_d; ilp_q <= ilp_d; cf_q <= cf_d;
      st_q <= st_d; sa_q <= sa_d; lt_q <= lt_d; la_q <= la_d;
      lock_q <= lock_d; il_q <= il_d;
    end
  end

  assign st_o      = st_q;
  assign sa_o      = sa_q;
  assign lt_o      = lt_q;
  assign la_o      = la_q;
  assign lock_o    = lock_q;
  assign il_o      = il_q;
  assign publish_o = publish && !clr;
endmodule

// File: rtl/raster_fmt_detect.sv
module raster_fmt_detect import rfd_pkg::*; #(
  parameter int DATA_W     = 10,
  parameter int SAMP_W     = 13,
  parameter int LINE_W     = 11,
  parameter int PUB_LINE   = 12,
  parameter int WDOG_W     = 16,
  parameter int WDOG_LIMIT = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              std_mode,
  input  logic              proc_en,
  input  logic              src_sel,
  input  logic [DATA_W-1:0] vid_data,
  input  logic              ext_h,
  input  logic              ext_v,
  input  logic              ext_f,
  output logic [SAMP_W-1:0] samples_total,
  output logic [SAMP_W-1:0] samples_active,
  output logic [LINE_W-1:0] lines_total,
  output logic [LINE_W-1:0] lines_active,
  output logic              std_locked,
  output logic              interlaced
);
  logic     rst_n_s;
  logic     en, dis;
  logic     wd_exp, meas_clr, pub_pulse;
  rfd_evt_t trs_evt, ext_evt, sel_evt;
  logic [2:0] act_off;

  assign en       = std_mode && proc_en;
  assign dis      = !en;
  assign meas_clr = dis || wd_exp;

  rfd_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  rfd_trs_decode #(.DATA_W(DATA_W)) u_trs (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clr   (dis),
    .din   (vid_data),
    .evt   (trs_evt)
  );

  rfd_ext_decode u_ext (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clr   (dis),
    .h_in  (ext_h),
    .v_in  (ext_v),
    .f_in  (ext_f),
    .evt   (ext_evt)
  );

  always_comb begin
    sel_evt = src_sel ? ext_evt : trs_evt;
    act_off = src_sel ? EXT_ACT_OFFSET : TRS_ACT_OFFSET;
  end

  rfd_watchdog #(.CNT_W(WDOG_W), .LIMIT(WDOG_LIMIT)) u_wdog (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .clr     (dis),
    .evt_vld (sel_evt.vld),
    .expired (wd_exp)
  );

  rfd_measure #(.SAMP_W(SAMP_W), .LINE_W(LINE_W), .PUB_LINE(PUB_LINE)) u_meas (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .clr       (meas_clr),
    .evt       (sel_evt),
    .act_off   (act_off),
    .st_o      (samples_total),
    .sa_o      (samples_active),
    .lt_o      (lines_total),
    .la_o      (lines_active),
    .lock_o    (std_locked),
    .il_o      (interlaced),
    .publish_o (pub_pulse)
  );
endmodule

// File: rtl/rfd_checker.sv
module rfd_checker #(
  parameter int SW = 13,
  parameter int LW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          std_mode,
  input logic          proc_en,
  input logic          publish,
  input logic          wd_expired,
  input logic [SW-1:0] samples_total,
  input logic [SW-1:0] samples_active,
  input logic [LW-1:0] lines_total,
  input logic [LW-1:0] lines_active,
  input logic          std_locked,
  input logic          interlaced
);
  // R5: outputs move only on a publish, a watchdog expiry or a disable
  assert_hold_between_updates_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!publish && !wd_expired && std_mode && proc_en) |=>
      ($stable(samples_total) && $stable(samples_active) && $stable(lines_total) &&
       $stable(lines_active) && $stable(std_locked) && $stable(interlaced)));

  // R6: lock may only rise on an update
  assert_lock_rise_on_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(std_locked) |-> $past(publish));

  // R6: lock implies non-zero totals
  assert_lock_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    std_locked |-> (samples_total != '0 && lines_total != '0));

  // R8: watchdog expiry clears lock and counts
  assert_wdog_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expired |=> (!std_locked && samples_total == '0 && samples_active == '0 &&
                    lines_total == '0 && lines_active == '0));

  // R9: disabled processing holds everything at zero
  assert_disable_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(std_mode && proc_en) |=> (!std_locked && !interlaced && samples_total == '0 &&
      samples_active == '0 && lines_total == '0 && lines_active == '0));
endmodule

bind raster_fmt_detect rfd_checker #(.SW(SAMP_W), .LW(LINE_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .std_mode       (std_mode),
  .proc_en        (proc_en),
  .publish        (pub_pulse),
  .wd_expired     (wd_exp),
  .samples_total  (samples_total),
  .samples_active (samples_active),
  .lines_total    (lines_total),
  .lines_active   (lines_active),
  .std_locked     (std_locked),
  .interlaced     (interlaced)
);

// File: tb/sim_raster_fmt_detect.sv
module sim_raster_fmt_detect;
  localparam int DW = 10;
  localparam int SW = 6;
  localparam int LW = 5;
  localparam int WL = 200;
  localparam int SMAX = (1 << SW) - 1;
  localparam int LMAX = (1 << LW) - 1;

  logic clk, rst_n, std_mode, proc_en, src_sel, ext_h, ext_v, ext_f;
  logic [DW-1:0] vid_data;
  logic [SW-1:0] samples_total, samples_active;
  logic [LW-1:0] lines_total, lines_active;
  logic std_locked, interlaced;

  raster_fmt_detect #(.DATA_W(DW), .SAMP_W(SW), .LINE_W(LW), .PUB_LINE(12),
                      .WDOG_W(16), .WDOG_LIMIT(WL)) u0 (
    .clk(clk), .rst_n(rst_n), .std_mode(std_mode), .proc_en(proc_en),
    .src_sel(src_sel), .vid_data(vid_data), .ext_h(ext_h), .ext_v(ext_v),
    .ext_f(ext_f), .samples_total(samples_total), .samples_active(samples_active),
    .lines_total(lines_total), .lines_active(lines_active),
    .std_locked(std_locked), .interlaced(interlaced));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  typedef struct {
    int st; int sa; int lt; int la; int lk; int il;
    string req;
  } exp_t;
  exp_t sb_q[$];
  event chk_ev;

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(int x, int m);
    return (x > m) ? m : x;
  endfunction

  // Monitor: pops expected sets and compares against the outputs
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk({e.req, " samples_total"},  int'(samples_total),  e.st);
        chk({e.req, " samples_active"}, int'(samples_active), e.sa);
        chk({e.req, " lines_total"},    int'(lines_total),    e.lt);
        chk({e.req, " lines_active"},   int'(lines_active),   e.la);
        chk({e.req, " std_locked"},     int'(std_locked),     e.lk);
        chk({e.req, " interlaced"},     int'(interlaced),     e.il);
      end
    end
  end

  task automatic push_exp(int st, int sa, int lt, int la, int lk, int il, string req);
    exp_t e;
    e.st = st; e.sa = sa; e.lt = lt; e.la = la; e.lk = lk; e.il = il; e.req = req;
    sb_q.push_back(e);
    -> chk_ev;
    @(negedge clk);
  endtask

  task automatic word(logic [DW-1:0] d);
    @(negedge clk);
    vid_data = d;
  endtask

  // One line with embedded codes (R1): EAV, blanking, SAV, active words
  task automatic trs_line(int t, int a, bit v, bit f);
    logic [DW-1:0] xyz;
    xyz = 10'h200 | (DW'(f) << 8) | (DW'(v) << 7);
    word(10'h3FF); word(10'h000); word(10'h000); word(xyz | 10'h040);
    for (int i = 0; i < t - a - 8; i++) word(10'h040);
    word(10'h3FF); word(10'h000); word(10'h000); word(xyz);
    for (int i = 0; i < a; i++) word(10'h155);
  endtask

  // One line on external timing (R1): H high in blanking
  task automatic ext_line(int t, int a, bit v, bit f);
    for (int i = 0; i < t; i++) begin
      @(negedge clk);
      ext_h = (i < t - a);
      ext_v = v;
      ext_f = f;
    end
  endtask

  task automatic lines(bit ext, int t, int a, int nvb, bit f, int first, int last);
    for (int ln = first; ln <= last; ln++) begin
      if (ext) ext_line(t, a, ln <= nvb, f);
      else     trs_line(t, a, ln <= nvb, f);
    end
  endtask

  task automatic frame(bit ext, int t, int a, int l, int nvb, bit il);
    lines(ext, t, a, nvb, 1'b0, 1, l);
    if (il) lines(ext, t, a, nvb, 1'b1, 1, l);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) word(10'h040);
  endtask

  task automatic chk_zero(string req);
    chk({req, " samples_total"},  int'(samples_total),  0);
    chk({req, " samples_active"}, int'(samples_active), 0);
    chk({req, " lines_total"},    int'(lines_total),    0);
    chk({req, " lines_active"},   int'(lines_active),   0);
    chk({req, " std_locked"},     int'(std_locked),     0);
    chk({req, " interlaced"},     int'(interlaced),     0);
  endtask

  task automatic pulse_disable(bit use_mode);
    @(negedge clk);
    if (use_mode) std_mode = 1'b0; else proc_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic enable_all();
    std_mode = 1'b1;
    proc_en  = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; std_mode = 1'b1; proc_en = 1'b1; src_sel = 1'b0;
    vid_data = 10'h040; ext_h = 1'b0; ext_v = 1'b0; ext_f = 1'b0;
    repeat (3) @(negedge clk);
    chk_zero("R11 reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Update point: first frame, before and after line 12 ends (R5)
    lines(1'b0, 40, 24, 6, 1'b0, 1, 12);
    chk("R5 before line-12 end samples_total", int'(samples_total), 0);
    word(10'h3FF); word(10'h000); word(10'h000); word(10'h240);
    word(10'h040); word(10'h040);
    chk("R5 after line-12 end samples_total", int'(samples_total), 40);
    chk("R5 after line-12 end lines_total (no field yet)", int'(lines_total), 0);
    idle(2);
    lines(1'b0, 40, 24, 6, 1'b0, 14, 16);
    // Progressive embedded raster: R2 R3 R4, lock on third update (R6)
    frame(1'b0, 40, 24, 16, 6, 1'b0);
    push_exp(40, 24, 16, 10, 0, 0, "R2 R3 R4 R6 frame2");
    frame(1'b0, 40, 24, 16, 6, 1'b0);
    push_exp(40, 24, 16, 10, 1, 0, "R6 lock frame3");

    // Disable through proc_en then std_mode (R9)
    pulse_disable(1'b0);
    chk_zero("R9 proc_en low");
    enable_all();
    pulse_disable(1'b1);
    chk_zero("R9 std_mode low");
    enable_all();

    // Interlaced embedded raster (R7)
    frame(1'b0, 40, 24, 16, 6, 1'b1);
    frame(1'b0, 40, 24, 16, 6, 1'b1);
    push_exp(40, 24, 16, 10, 0, 1, "R7 interlaced frame2");
    frame(1'b0, 40, 24, 16, 6, 1'b1);
    push_exp(40, 24, 16, 10, 1, 1, "R7 R6 interlaced frame3");
    // Back to progressive: flag needs two constant-F frames (R7)
    frame(1'b0, 40, 24, 16, 6, 1'b0);
    push_exp(40, 24, 16, 10, 1, 1, "R7 prog after il p1");
    frame(1'b0, 40, 24, 16, 6, 1'b0);
    push_exp(40, 24, 16, 10, 1, 1, "R7 prog after il p2");
    frame(1'b0, 40, 24, 16, 6, 1'b0);
    push_exp(40, 24, 16, 10, 1, 0, "R7 prog after il p3");

    // Data stops, clock runs (R8)
    idle(WL + 50);
    chk_zero("R8 watchdog embedded");

    // External timing source (R1)
    pulse_disable(1'b0);
    src_sel = 1'b1;
    enable_all();
    frame(1'b1, 48, 30, 20, 5, 1'b0);
    frame(1'b1, 48, 30, 20, 5, 1'b0);
    push_exp(48, 30, 20, 15, 0, 0, "R1 R3 external frame2");
    frame(1'b1, 48, 30, 20, 5, 1'b0);
    push_exp(48, 30, 20, 15, 1, 0, "R1 R6 external frame3");
    // Hold H constant (R8)
    for (int i = 0; i < WL + 50; i++) @(negedge clk);
    chk_zero("R8 watchdog external");

    // Oversized raster saturates (R10)
    pulse_disable(1'b0);
    src_sel = 1'b0;
    ext_h = 1'b0;
    enable_all();
    frame(1'b0, 80, 24, 40, 6, 1'b0);
    frame(1'b0, 80, 24, 40, 6, 1'b0);
    push_exp(sat(80, SMAX), 24, sat(40, LMAX), sat(34, LMAX), 0, 0, "R10 saturate frame2");
    frame(1'b0, 80, 24, 40, 6, 1'b0);
    push_exp(sat(80, SMAX), 24, sat(40, LMAX), sat(34, LMAX), 1, 0, "R10 saturate frame3");

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog timeout actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule